// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a double-data-rate DRAM interface. It owns the command and address pins from reset until the memory is ready for traffic. It holds the clock-enable low and waits until the clock-stable input has been seen high for a fixed stretch of time. It then raises clock-enable and issues the mandatory ordered series of precharge, mode-register and refresh commands, with programmable no-operation gaps between them. When the series is complete it raises `init_done` and parks the bus on NOP, so that the normal controller can take over the pins.

The stretch of time is given in microseconds (`STABLE_US`) and is converted to cycles with the clock frequency parameter `CLK_MHZ`. The gaps are cycle counts: `TRP_CYC`, `TMRD_CYC`, `TRFC_CYC` and `DLL_LOCK_CYC`. `MODE_VAL` is the operating mode word and `EMR_VAL` is the extended mode word.

States and transitions:
- `ST_POWER_WAIT` moves to `ST_CKE_UP` after enough stable samples. A low sample reloads the wait count.
- `ST_CKE_UP` moves to `ST_PREA_FIRST`.
- Each command state (`ST_PREA_FIRST`, `ST_EMRS_DLL_ON`, `ST_MRS_DLL_RST`, `ST_PREA_SECOND`, `ST_AREF_FIRST`, `ST_AREF_SECOND`, `ST_MRS_RUN`) moves to `ST_GAP`, after recording the state to resume in.
- `ST_GAP` returns to the recorded state when its count runs out. After `ST_MRS_RUN` the recorded state is `ST_DONE`.
- `ST_DONE` is held until reset.
- A synchronous reset sends every state back to `ST_POWER_WAIT`.

Top module: `dram_pwrup_seq`

## Requirements
- R1: After a synchronous reset, and for the whole wait, `cke`=0, `init_done`=0, `ba`=0 and `addr`=0. The command pins show DESELECT, coded {cs_n,ras_n,cas_n,we_n}=4'b1111.
- R2: `cke` stays low until `clk_stable` has been sampled high on W = CLK_MHZ*STABLE_US consecutive rising edges. A low sample during the wait restarts the count. Once the wait is over, `clk_stable` has no effect.
- R3: In the cycle after the W-th stable sample, the block drives NOP (4'b0111) with `cke`=1. From then on `cke` stays 1 until reset.
- R4: One cycle after the NOP, the block issues PRECHARGE ALL. This is coded 4'b0010 with `addr` bit 10 set, all other address bits 0 and `ba`=0.
- R5: TRP_CYC cycles after the first precharge, the block issues MODE REGISTER SET (4'b0000) to the extended register. It carries `ba`=2'b01 and `addr`=EMR_VAL.
- R6: TMRD_CYC cycles later, the block issues MODE REGISTER SET to the main register. It carries `ba`=0 and `addr`=MODE_VAL with bit 8 (DLL reset) set.
- R7: DLL_LOCK_CYC cycles later (at least 200), the block issues the second PRECHARGE ALL, coded as in R4.
- R8: TRP_CYC cycles later, the block issues AUTO REFRESH (4'b0001, `ba`=0, `addr`=0). A second AUTO REFRESH follows TRFC_CYC cycles after the first.
- R9: TRFC_CYC cycles after the second refresh, the block issues MODE REGISTER SET to the main register. It carries `ba`=0 and `addr`=MODE_VAL with bit 8 cleared.
- R10: Every cycle between two commands of the script is NOP with `cke`=1, `ba`=0 and `addr`=0. Gaps shorter than 2 are raised to 2.
- R11: `init_done` rises TMRD_CYC cycles after the final MODE REGISTER SET and stays high until reset. While it is high the block drives NOP with `cke`=1.
- R12: A synchronous reset in any state, including during the script or after `init_done`, returns the block to the R1 condition. The full sequence then restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_stable | input | 1 | High once supplies and clock are stable |
| cke | output | 1 | DRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address / mode word |
| init_done | output | 1 | Sequence complete; bus may be handed over |

## Verification
The bench runs a short-wait configuration and compares every output pin on every cycle against a schedule of command times computed from the parameters. It first runs a clean sequence with `clk_stable` held high. It then runs one where `clk_stable` drops partway through the wait, which shows whether the count restarts or merely pauses. It also resets in the middle of the DLL-lock gap and after `init_done`, which shows whether the script restarts from the start rather than resuming. The mode words have distinct bits, so a swapped bank address or a wrong state of the DLL-reset bit is visible on the address pins.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

    typedef enum logic [3:0] {
        ST_POWER_WAIT,
        ST_CKE_UP,
        ST_PREA_FIRST,
        ST_EMRS_DLL_ON,
        ST_MRS_DLL_RST,
        ST_PREA_SECOND,
        ST_AREF_FIRST,
        ST_AREF_SECOND,
        ST_MRS_RUN,
        ST_GAP,
        ST_DONE
    } init_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_DESEL = 4'b1111;
    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_PRE   = 4'b0010;
    localparam logic [3:0] CMD_REF   = 4'b0001;
    localparam logic [3:0] CMD_MRS   = 4'b0000;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned gap_floor(input int unsigned g);
        return (g < 2) ? 2 : g;
    endfunction

endpackage

// File: rtl/dram_init_timer.sv
module dram_init_timer #(
    parameter int unsigned     TW      = 8,
    parameter logic [TW-1:0]   RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |-> (cnt_q != '0)); // R10

endmodule

// File: rtl/dram_init_cmd_drv.sv
module dram_init_cmd_drv
    import dram_init_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 13,
    parameter int unsigned       BA_W        = 2,
    parameter logic [ADDR_W-1:0] MODE_VAL    = '0,
    parameter logic [ADDR_W-1:0] EMR_VAL     = '0,
    parameter int unsigned       DLL_RST_BIT = 8,
    parameter int unsigned       AP_BIT      = 10
) (
    input  init_state_e        state,
    output logic               cke,
    output logic [3:0]         cmd,
    output logic [BA_W-1:0]    ba,
    output logic [ADDR_W-1:0]  addr,
    output logic               done
);

    localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RST_BIT;
    localparam logic [ADDR_W-1:0] AP_MASK  = ADDR_W'(1) << AP_BIT;

    always_comb begin
        cke  = 1'b1;
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        done = 1'b0;
        unique case (state)
            ST_POWER_WAIT: begin
                cke = 1'b0;
                cmd = CMD_DESEL;
            end
            ST_CKE_UP: ;
            ST_PREA_FIRST, ST_PREA_SECOND: begin
                cmd  = CMD_PRE;
                addr = AP_MASK;
            end
            ST_EMRS_DLL_ON: begin
                cmd  = CMD_MRS;
                ba   = BA_W'(1);
                addr = EMR_VAL;
            end
            ST_MRS_DLL_RST: begin
                cmd  = CMD_MRS;
                addr = MODE_VAL | DLL_MASK;
            end
            ST_AREF_FIRST, ST_AREF_SECOND: begin
                cmd = CMD_REF;
            end
            ST_MRS_RUN: begin
                cmd  = CMD_MRS;
                addr = MODE_VAL & ~DLL_MASK;
            end
            ST_GAP: ;
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                cke = 1'b0;
                cmd = CMD_DESEL;
            end
        endcase
    end

endmodule

// File: rtl/dram_pwrup_seq.sv
module dram_pwrup_seq
    import dram_init_pkg::*;
#(
    parameter int unsigned       CLK_MHZ      = 200,
    parameter int unsigned       STABLE_US    = 200,
    parameter int unsigned       TRP_CYC      = 4,
    parameter int unsigned       TMRD_CYC     = 2,
    parameter int unsigned       TRFC_CYC     = 16,
    parameter int unsigned       DLL_LOCK_CYC = 200,
    parameter int unsigned       ADDR_W       = 13,
    parameter int unsigned       BA_W         = 2,
    parameter logic [ADDR_W-1:0] MODE_VAL     = 13'h032,
    parameter logic [ADDR_W-1:0] EMR_VAL      = 13'h000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_stable,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int unsigned WAIT_CYC = (CLK_MHZ * STABLE_US < 1) ? 1 : CLK_MHZ * STABLE_US;
    localparam int unsigned TRP_G    = gap_floor(TRP_CYC);
    localparam int unsigned TMRD_G   = gap_floor(TMRD_CYC);
    localparam int unsigned TRFC_G   = gap_floor(TRFC_CYC);
    localparam int unsigned DLL_G    = umax(gap_floor(DLL_LOCK_CYC), TMRD_G);
    localparam int unsigned LONGEST  = umax(WAIT_CYC, umax(DLL_G, umax(TRFC_G, umax(TRP_G, TMRD_G))));
    localparam int unsigned TW       = $clog2(LONGEST + 1);

    // wait counts N samples: load N-1; gaps hold G-1 NOP cycles: load G-2
    localparam logic [TW-1:0] WAIT_LD = TW'(WAIT_CYC - 1);
    localparam logic [TW-1:0] TRP_LD  = TW'(TRP_G - 2);
    localparam logic [TW-1:0] TMRD_LD = TW'(TMRD_G - 2);
    localparam logic [TW-1:0] TRFC_LD = TW'(TRFC_G - 2);
    localparam logic [TW-1:0] DLL_LD  = TW'(DLL_G - 2);

    init_state_e   state_q, state_d;
    init_state_e   ret_q, ret_d;
    logic          tmr_load, tmr_dec, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic [3:0]    cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_POWER_WAIT;
            ret_q   <= ST_POWER_WAIT;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        ret_d    = ret_q;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_POWER_WAIT: begin
                if (!clk_stable) begin
                    tmr_load = 1'b1;
                    tmr_val  = WAIT_LD;
                end else if (tmr_zero) begin
                    state_d = ST_CKE_UP;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_CKE_UP:      state_d = ST_PREA_FIRST;
            ST_PREA_FIRST: begin
                state_d = ST_GAP; ret_d = ST_EMRS_DLL_ON;
                tmr_load = 1'b1;  tmr_val = TRP_LD;
            end
            ST_EMRS_DLL_ON: begin
                state_d = ST_GAP; ret_d = ST_MRS_DLL_RST;
                tmr_load = 1'b1;  tmr_val = TMRD_LD;
            end
            ST_MRS_DLL_RST: begin
                state_d = ST_GAP; ret_d = ST_PREA_SECOND;
                tmr_load = 1'b1;  tmr_val = DLL_LD;
            end
            ST_PREA_SECOND: begin
                state_d = ST_GAP; ret_d = ST_AREF_FIRST;
                tmr_load = 1'b1;  tmr_val = TRP_LD;
            end
            ST_AREF_FIRST: begin
                state_d = ST_GAP; ret_d = ST_AREF_SECOND;
                tmr_load = 1'b1;  tmr_val = TRFC_LD;
            end
            ST_AREF_SECOND: begin
                state_d = ST_GAP; ret_d = ST_MRS_RUN;
                tmr_load = 1'b1;  tmr_val = TRFC_LD;
            end
            ST_MRS_RUN: begin
                state_d = ST_GAP; ret_d = ST_DONE;
                tmr_load = 1'b1;  tmr_val = TMRD_LD;
            end
            ST_GAP: begin
                if (tmr_zero) state_d = ret_q;
                else          tmr_dec = 1'b1;
            end
            ST_DONE: ;
            default: state_d = ST_POWER_WAIT;
        endcase
    end

    dram_init_timer #(
        .TW      (TW),
        .RST_VAL (WAIT_LD)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    dram_init_cmd_drv #(
        .ADDR_W      (ADDR_W),
        .BA_W        (BA_W),
        .MODE_VAL    (MODE_VAL),
        .EMR_VAL     (EMR_VAL),
        .DLL_RST_BIT (8),
        .AP_BIT      (10)
    ) u_cmd (
        .state (state_q),
        .cke   (cke),
        .cmd   (cmd),
        .ba    (ba),
        .addr  (addr),
        .done  (init_done)
    );

    assign {cs_n, ras_n, cas_n, we_n} = cmd;

    logic is_exec;
    assign is_exec = !cs_n && !(ras_n && cas_n && we_n);

    AST_DESEL_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
        !cke |-> cs_n); // R1
    AST_WAIT_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POWER_WAIT && !clk_stable) |=> !cke); // R2
    AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke); // R3
    AST_NOP_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
        is_exec |=> !is_exec); // R10
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R11
    AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cke && !cs_n && ras_n && cas_n && we_n)); // R11

endmodule

// File: tb/dram_pwrup_seq_bench.sv
module dram_pwrup_seq_bench;

    localparam time         CLK_PERIOD = 10ns;
    localparam int          W    = 200;   // CLK_MHZ=1, STABLE_US=200
    localparam int          TRP  = 3;
    localparam int          TMRD = 2;
    localparam int          TRFC = 5;
    localparam int          DLL  = 200;
    localparam logic [12:0] MODE = 13'h032;
    localparam logic [12:0] EMR  = 13'h002;

    localparam int T_N  = W;
    localparam int T_P1 = T_N + 1;
    localparam int T_E  = T_P1 + TRP;
    localparam int T_M1 = T_E + TMRD;
    localparam int T_P2 = T_M1 + DLL;
    localparam int T_A1 = T_P2 + TRP;
    localparam int T_A2 = T_A1 + TRFC;
    localparam int T_M2 = T_A2 + TRFC;
    localparam int T_D  = T_M2 + TMRD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_stable = 1'b0;
    logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [1:0]  ba;
    logic [12:0] addr;

    int checks   = 0;
    int failures = 0;
    int c        = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_pwrup_seq #(
        .CLK_MHZ (1), .STABLE_US (200),
        .TRP_CYC (TRP), .TMRD_CYC (TMRD), .TRFC_CYC (TRFC), .DLL_LOCK_CYC (DLL),
        .ADDR_W (13), .BA_W (2), .MODE_VAL (MODE), .EMR_VAL (EMR)
    ) u_dram_pwrup_seq (
        .clk (clk), .rst (rst), .clk_stable (clk_stable),
        .cke (cke), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr), .init_done (init_done)
    );

    // packed {done, cke, cs_n,ras_n,cas_n,we_n, ba[1:0], addr[12:0]}
    function automatic logic [20:0] exp_out(input int k);
        logic [3:0] cm; logic [1:0] b; logic [12:0] a; logic ck, d;
        ck = 1'b1; d = 1'b0; cm = 4'b0111; b = 2'b00; a = '0;
        if (k < W)                     begin ck = 1'b0; cm = 4'b1111; end
        else if (k == T_P1 || k == T_P2) begin cm = 4'b0010; a = 13'h400; end
        else if (k == T_E)             begin cm = 4'b0000; b = 2'b01; a = EMR; end
        else if (k == T_M1)            begin cm = 4'b0000; a = MODE | 13'h100; end
        else if (k == T_A1 || k == T_A2) cm = 4'b0001;
        else if (k == T_M2)            begin cm = 4'b0000; a = MODE & ~13'h100; end
        else if (k >= T_D)             d = 1'b1;
        return {d, ck, cm, b, a};
    endfunction

    function automatic string tag_of(input int k);
        if (k < W)                        return "R2";
        if (k == T_N)                     return "R3";
        if (k == T_P1)                    return "R4";
        if (k == T_E)                     return "R5";
        if (k == T_M1)                    return "R6";
        if (k == T_P2)                    return "R7";
        if (k == T_A1 || k == T_A2)       return "R8";
        if (k == T_M2)                    return "R9";
        if (k >= T_D)                     return "R11";
        return "R10";
    endfunction

    // Called at a falling edge: drive, take one rising edge, sample at next falling edge.
    task automatic step(input logic rst_v, input logic stb_v, input string force_tag);
        logic [20:0] got, exp;
        string t;
        rst = rst_v;
        clk_stable = stb_v;
        @(posedge clk);
        if (rst_v)      c = 0;
        else if (c < W) c = stb_v ? c + 1 : 0;
        else            c = c + 1;
        @(negedge clk);
        got = {init_done, cke, cs_n, ras_n, cas_n, we_n, ba, addr};
        exp = exp_out(rst_v ? 0 : c);
        t = (force_tag != "") ? force_tag : tag_of(c);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", t, c, got, exp);
        end
    endtask

    task automatic run_to(input int target);
        while (c < target) step(1'b0, 1'b1, "");
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        repeat (3) step(1'b1, 1'b0, "R1");
        // R2: no stable -> hold
        repeat (20) step(1'b0, 1'b0, "R2");
        // R2: partial wait then drop, count must restart
        repeat (100) step(1'b0, 1'b1, "R2");
        repeat (5) step(1'b0, 1'b0, "R2");
        // full clean script, then R2 stable ignored after wait
        run_to(T_P1 + 1);
        repeat (10) step(1'b0, 1'b0, "");
        run_to(T_D + 20);
        // R12: reset inside the DLL-lock gap
        repeat (2) step(1'b1, 1'b1, "R12");
        run_to(T_M1 + 50);
        repeat (2) step(1'b1, 1'b0, "R12");
        run_to(T_D + 5);
        // R12: reset after done, rerun, R11 sticky
        repeat (2) step(1'b1, 1'b1, "R12");
        run_to(T_D + 40);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule